// File: doc/BRIEF.md
# Digital Input Deglitch Filter

This block conditions a bank of digital inputs, grouped into 8-bit ports, before they reach the data read path and the edge detectors. Every raw input is first brought into the clock domain through a two-flop synchroniser. A channel whose filter is switched on only passes a new level once that level has stayed put for a programmed number of 200 ns ticks. A channel whose filter is off follows its synchronised input directly.

One interval register, shared by all channels, holds the hold-off time. Each port has its own 8-bit enable register, one bit per channel. Software sets both through a small register write port: word accesses for the interval and byte accesses for the enables. A free-running prescaler divides the system clock into the 200 ns tick. The ratio is a parameter, for example 20 at 100 MHz.

Top module: `inflt_top`

## Requirements
- R1: After reset, the interval register and every enable register read 0, and all filtered outputs are 0.
- R2: A word write (wr_word=1) to address 0x08 stores bits 19:0 of wr_data as the interval. A word read of 0x08 returns that value with bits 31:20 as zero, so writing all ones reads back 0x000FFFFF.
- R3: The enable register for port p sits at byte address 0x44 + 16·p. Its bit b controls channel 8·p + b. A byte write (wr_word=0) stores wr_data[7:0] there, and a byte read returns it in rd_data[7:0] with the upper bits zero.
- R4: A byte write to the interval address, or a word write to an enable address, leaves every register unchanged.
- R5: A channel whose enable bit is 0 shows a change of its raw input on its filtered output exactly 3 clock cycles later.
- R6: With enable 1 and interval N > 0, a change of the raw input is not visible for (N−1)·TICK_DIV+2 cycles. It is visible within N·TICK_DIV+3 cycles, provided the input holds.
- R7: On an enabled channel, an excursion of the raw input that returns to the output level before N ticks have elapsed never reaches the output. After such a bounce, a new change again needs the full interval.
- R8: An interval of 0 makes enabled channels behave like unfiltered ones, with the exact 3-cycle latency of R5.
- R9: Channels are independent. Filtering on one port does not delay the channels of a port whose enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 1 | 1: word access, 0: byte access |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Write data |
| rd_word | input | 1 | 1: word read, 0: byte read |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Combinational read data |
| raw_in | input | 8·NUM_PORTS | Raw asynchronous inputs |
| filt_out | output | 8·NUM_PORTS | Filtered, synchronised inputs |

## Verification
The assertions assume the raw inputs are the only asynchronous signals. They also assume the register port obeys the access-size convention, so that a read or write is interpreted only by its address and size. The stimulus changes raw inputs and register controls only at the falling clock edge and holds each raw level for whole cycles. Bounces are generated as runs of several cycles, so the synchroniser never samples a transition that the bench has not accounted for. Timing checks are placed at cycle counts derived from the tick period and the interval, which makes them valid for any phase of the free-running prescaler.

// File: rtl/inflt_pkg.sv
// Shared constants and types for the input deglitch filter.
// Assumes 8-bit ports and a 20-bit interval counted in prescaler ticks.
package inflt_pkg;
    localparam int PORT_W      = 8;
    localparam int IVL_W       = 20;
    localparam int IVL_ADDR    = 'h08;
    localparam int EN_BASE     = 'h44;
    localparam int PORT_STRIDE = 'h10;

    typedef logic [IVL_W-1:0] ivl_t;
endpackage

// File: rtl/inflt_tick.sv
// Tick prescaler: emits a one-cycle pulse every TICK_DIV clock cycles.
// Assumes TICK_DIV >= 2; runs freely from reset.
module inflt_tick #(
    parameter int TICK_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    // Count clock cycles and pulse on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick  <= (div_q == LAST);
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/inflt_sync.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module inflt_sync #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/inflt_regs.sv
// Interval and per-port enable registers with a byte/word access port.
// Assumes word accesses target the interval and byte accesses the enables;
// other combinations are ignored on write and read as zero.
module inflt_regs
    import inflt_pkg::*;
#(
    parameter int NUM_PORTS = 12,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_word,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic                        rd_word,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [31:0]                 rd_data,
    output ivl_t                        ivl_q,
    output logic [NUM_PORTS*PORT_W-1:0] en_q
);
    logic ivl_hit;
    assign ivl_hit = wr_en && wr_word && (32'(wr_addr) == IVL_ADDR);

    // Interval register keeps only the meaningful low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ivl_q <= '0;
        else if (ivl_hit) ivl_q <= wr_data[IVL_W-1:0];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int ADDR = EN_BASE + p * PORT_STRIDE;
        logic hit;
        assign hit = wr_en && !wr_word && (32'(wr_addr) == ADDR);

        // Per-port enable byte, written by byte access only.
        always_ff @(posedge clk) begin
            if (!rst_n)   en_q[p*PORT_W +: PORT_W] <= '0;
            else if (hit) en_q[p*PORT_W +: PORT_W] <= wr_data[PORT_W-1:0];
        end
    end

    // Read multiplexer: interval by word, enables by byte.
    always_comb begin
        rd_data = '0;
        if (rd_word && (32'(rd_addr) == IVL_ADDR))
            rd_data = 32'(ivl_q);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (!rd_word && (32'(rd_addr) == EN_BASE + p * PORT_STRIDE))
                rd_data = 32'(en_q[p*PORT_W +: PORT_W]);
        end
    end
endmodule

// File: rtl/inflt_chan.sv
// One channel's stability filter: passes a new level after it has differed
// from the output for ivl consecutive ticks. Assumes a synchronised input.
module inflt_chan
    import inflt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  ivl_t ivl,
    input  logic din,
    output logic dout
);
    ivl_t cnt_q;

    // Stability counter and output update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b0;
            cnt_q <= '0;
        end else if (!en || (ivl == '0)) begin
            dout  <= din;
            cnt_q <= '0;
        end else if (din == dout) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q >= ivl - 1'b1) begin
                dout  <= din;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/inflt_top.sv
// Input deglitch filter top: synchroniser, tick prescaler, registers and
// one stability filter per channel. Assumes raw_in is asynchronous.
module inflt_top
    import inflt_pkg::*;
#(
    parameter int NUM_PORTS = 12,
    parameter int TICK_DIV  = 20,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_word,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic                        rd_word,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [31:0]                 rd_data,
    input  logic [NUM_PORTS*8-1:0]      raw_in,
    output logic [NUM_PORTS*8-1:0]      filt_out
);
    localparam int NCH = NUM_PORTS * PORT_W;

    logic           tick;
    logic [NCH-1:0] sync_vec;
    logic [NCH-1:0] en_vec;
    ivl_t           ivl_q;

    inflt_tick #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    inflt_sync #(.W(NCH)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_vec)
    );

    inflt_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .ivl_q(ivl_q), .en_q(en_vec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        inflt_chan chan_i (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .en(en_vec[c]), .ivl(ivl_q),
            .din(sync_vec[c]), .dout(filt_out[c])
        );
    end
endmodule

// File: rtl/inflt_chk.sv
// Property checker for the input deglitch filter, bound to inflt_top.
// Assumes a synchronous active-low reset held from time zero.
module inflt_chk #(
    parameter int NCH    = 96,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NCH-1:0]    sync_vec,
    input logic [NCH-1:0]    en_vec,
    input logic [19:0]       ivl_q,
    input logic [NCH-1:0]    filt_out,
    input logic              rd_word,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data
);
    // R1: outputs are clear in the first cycle out of reset
    a_r1_out_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (filt_out == '0));

    // R2: interval reads never carry bits above the meaningful field
    a_r2_ivl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && (32'(rd_addr) == 'h08)) |-> (rd_data[31:20] == '0));

    // R3: byte reads return only eight bits
    a_r3_byte_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word |-> (rd_data[31:8] == '0));

    // R6: prescaler pulses last a single cycle
    a_r6_tick_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6: a filtered channel changes only on a tick
        a_r6_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_out[c] != $past(filt_out[c])) |->
                ($past(tick) || !$past(en_vec[c]) || ($past(ivl_q) == '0)));

        // R5: any output change takes the synchronised input value
        a_r5_change_takes_sync: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_out[c] != $past(filt_out[c])) |-> (filt_out[c] == $past(sync_vec[c])));
    end
endmodule

bind inflt_top inflt_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_vec(sync_vec),
    .en_vec(en_vec), .ivl_q(ivl_q), .filt_out(filt_out),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/inflt_top_tb_top.sv
// Self-checking bench for inflt_top on a two-port, divide-by-four setup.
module inflt_top_tb_top;
    localparam int NP  = 2;
    localparam int NCH = NP * 8;
    localparam int DIV = 4;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0, wr_word = 1'b0, rd_word = 1'b0;
    logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0]    wr_data = '0, rd_data;
    logic [NCH-1:0] raw_in = '0, filt_out;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    always #5 clk = ~clk;

    inflt_top #(.NUM_PORTS(NP), .TICK_DIV(DIV), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_word(rd_word), .rd_addr(rd_addr), .rd_data(rd_data),
        .raw_in(raw_in), .filt_out(filt_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_word = word; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic word, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_word = word; rd_addr = a;
        #1 d = rd_data;
    endtask

    // Exact three-cycle pass-through on one channel, both edges.
    task automatic pass_test(input string req, input int ch);
        logic [NCH-1:0] old_v;
        for (int e = 0; e < 2; e++) begin
            old_v = raw_in;
            raw_in[ch] = ~raw_in[ch];
            cyc(2);
            chk(req, 32'(filt_out), 32'(old_v));
            cyc(1);
            chk(req, 32'(filt_out), 32'(raw_in));
        end
    endtask

    // Hold-off and completion bounds for interval n on one channel.
    task automatic filt_test(input string req, input int ch, input int n);
        logic [NCH-1:0] old_v;
        for (int e = 0; e < 2; e++) begin
            old_v = raw_in;
            raw_in[ch] = ~raw_in[ch];
            cyc((n - 1) * DIV + 2);
            chk(req, 32'(filt_out), 32'(old_v));
            cyc(DIV + 1);
            chk(req, 32'(filt_out), 32'(raw_in));
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        bit moved;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 outputs", 32'(filt_out), 32'h0);
        rd(1'b1, 8'h08, d); chk("R1 interval", d, 32'h0);
        rd(1'b0, 8'h44, d); chk("R1 enable p0", d, 32'h0);
        rd(1'b0, 8'h54, d); chk("R1 enable p1", d, 32'h0);

        // R2: interval width
        wr(1'b1, 8'h08, 32'hFFFF_FFFF);
        rd(1'b1, 8'h08, d); chk("R2 all ones", d, 32'h000F_FFFF);
        wr(1'b1, 8'h08, 32'hABC1_2345);
        rd(1'b1, 8'h08, d); chk("R2 pattern", d, 32'h0001_2345);

        // R4: wrong access size is ignored
        wr(1'b0, 8'h08, 32'h0000_00AA);
        rd(1'b1, 8'h08, d); chk("R4 byte to interval", d, 32'h0001_2345);
        wr(1'b1, 8'h44, 32'hFFFF_FFFF);
        rd(1'b0, 8'h44, d); chk("R4 word to enable", d, 32'h0);

        // R3: enable registers per port
        wr(1'b0, 8'h44, 32'h1234_56A5);
        wr(1'b0, 8'h54, 32'h0000_003C);
        rd(1'b0, 8'h44, d); chk("R3 port0", d, 32'hA5);
        rd(1'b0, 8'h54, d); chk("R3 port1", d, 32'h3C);
        wr(1'b0, 8'h44, 32'h0);
        wr(1'b0, 8'h54, 32'h0);

        // R5: unfiltered channels, every channel
        wr(1'b1, 8'h08, 32'd3);
        cyc(20);
        for (int c = 0; c < NCH; c++) pass_test("R5 unfiltered", c);

        // R8: interval zero with filtering enabled
        wr(1'b1, 8'h08, 32'd0);
        wr(1'b0, 8'h44, 32'hFF);
        wr(1'b0, 8'h54, 32'hFF);
        cyc(20);
        for (int c = 0; c < NCH; c++) pass_test("R8 zero interval", c);

        // R6: interval sweep on varying channels
        for (int n = 1; n <= 5; n++) begin
            wr(1'b1, 8'h08, 32'(n));
            cyc(20);
            filt_test("R6 interval", (n * 5) % NCH, n);
        end

        // R9: port 0 filtered, port 1 unfiltered
        wr(1'b1, 8'h08, 32'd3);
        wr(1'b0, 8'h54, 32'h00);
        cyc(20);
        raw_in = '1;
        cyc(3);
        chk("R9 mixed rise early", 32'(filt_out), 32'hFF00);
        cyc(3 * DIV);
        chk("R9 mixed rise late", 32'(filt_out), 32'hFFFF);
        raw_in = '0;
        cyc(3);
        chk("R9 mixed fall early", 32'(filt_out), 32'h00FF);
        cyc(3 * DIV);
        chk("R9 mixed fall late", 32'(filt_out), 32'h0000);

        // R7: bounces shorter than the interval, then a restarted hold
        wr(1'b0, 8'h44, 32'hFF);
        cyc(20);
        moved = 0;
        for (int b = 0; b < 6; b++) begin
            raw_in[5] = 1'b1;
            for (int k = 0; k < DIV; k++) begin
                cyc(1);
                if (filt_out != '0) moved = 1;
            end
            raw_in[5] = 1'b0;
            for (int k = 0; k < DIV; k++) begin
                cyc(1);
                if (filt_out != '0) moved = 1;
            end
        end
        chk("R7 bounce suppressed", 32'(moved), 32'h0);
        filt_test("R7 restart after bounce", 5, 3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule